// File: doc/BRIEF.md
# BCH Error Fix-Up Engine

This block takes the error report of a BCH decoder for one sector and repairs the affected bytes in place. It receives the sector index, the number of reported errors, a set of packed error-address words and a set of packed error-mask words. For each error it works out where the flipped byte lives and XORs the mask into that byte. An error can fall in one of three places: the sector payload, the three protected spare bytes at the front of the spare area, or the sector's parity bytes near the end of the spare area.

The payload sits in a byte-wide memory. The spare area sits in a word-wide memory, so a repair there is a read, a lane XOR and a write-back of a 32-bit word. Both memories have a one-cycle read latency. The controller pulses `start` with all job fields valid. The block copies the fields into its own registers, repairs the errors one at a time in ascending order, and pulses `done` when it has finished.

Top module: `bch_err_apply`

## Requirements
- R1: During and right after reset, `busy`, `done`, `err` and all four memory strobes are low.
- R2: Error i takes its 11-bit address from address word i/2: bits 10:0 when i is even, bits 26:16 when i is odd. All other bits of the word are ignored.
- R3: Error i takes its 8-bit mask from data word i/4, byte lane i%4, where lane k is bits 8k+7:8k.
- R4: Strength code 0 (T=8) and code 1 (T=12) use a 512-byte sector. Code 2 (T=24) uses a 1024-byte sector. An error address A below the sector size S is XORed into payload byte `sector_idx*S + A`.
- R5: An address A from S to S+2 is XORed into byte lane A−S of spare word 0.
- R6: For a higher address, the parity length P is 15, 23 or 45 bytes and the padding D is 32, 32 or 64 bytes, for codes 0, 1 and 2. The byte offset is `spare_size[8:0] − P*sector_cnt + P*sector_idx + (A − (S + D − P))`. The block XORs lane offset%4 of spare word offset/4. Bits 31:9 of `spare_size` are ignored.
- R7: Every repair reads a word, then writes the XORed word to the same address in the next cycle, on one memory only.
- R8: Errors are applied in ascending index order. An error count of 0 applies nothing. A count above 24 is treated as 24.
- R9: `busy` rises in the cycle after `start` is accepted. `done` is a one-cycle pulse in the last busy cycle, so a job of N errors reports `done` 2N+1 cycles after it is accepted.
- R10: Strength code 3 makes no memory access and raises `err` together with `done`.
- R11: A `start` that arrives while `busy` is high is ignored, and so are changes to the job inputs during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a job (only when idle) |
| strength | input | 2 | 0: T=8, 1: T=12, 2: T=24, 3: unsupported |
| sector_idx | input | IDX_W | Index of the sector being repaired |
| sector_cnt | input | CNT_W | Sectors per page |
| err_cnt | input | 5 | Number of reported errors |
| spare_size | input | 32 | Spare-size setting; only bits 8:0 are used |
| err_addr_words | input | 384 | Twelve packed address words |
| err_data_words | input | 192 | Six packed mask words |
| dmem_rd | output | 1 | Payload read strobe |
| dmem_wr | output | 1 | Payload write strobe |
| dmem_addr | output | DADDR_W | Payload byte address |
| dmem_wdata | output | 8 | Payload write data |
| dmem_rdata | input | 8 | Payload read data, one cycle after `dmem_rd` |
| smem_rd | output | 1 | Spare read strobe |
| smem_wr | output | 1 | Spare write strobe |
| smem_addr | output | SADDR_W | Spare word address |
| smem_wdata | output | 32 | Spare write data |
| smem_rdata | input | 32 | Spare read data, one cycle after `smem_rd` |
| busy | output | 1 | Job in progress |
| done | output | 1 | End-of-job pulse |
| err | output | 1 | Unsupported strength, pulsed with `done` |

## Verification
The hardest case to reach from the ports is a parity-region error. Its address must land exactly inside the window S+D−P to S+D−1, and the spare size must be large enough that the remapped offset stays clear of the protected bytes. The stimulus generator builds its addresses per region from those formulas and draws the spare size above P*sector_cnt+4, with random upper bits. Several errors aimed at the same spare word exercise the read-modify-write chain, and a second `start`, sent with scrambled inputs while the block is busy, exercises the ignore rule.

// File: rtl/bch_fix_pkg.sv
package bch_fix_pkg;

    localparam int MAX_ERR = 24;
    localparam int AWORDS  = (MAX_ERR + 1) / 2;
    localparam int DWORDS  = (MAX_ERR + 3) / 4;
    localparam int EADDR_W = 11;

    typedef enum logic [1:0] {STR_T8 = 2'd0, STR_T12 = 2'd1, STR_T24 = 2'd2, STR_BAD = 2'd3} strength_e;
    typedef enum logic [1:0] {RG_DATA, RG_PROT, RG_PAR} region_e;
    typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FIN} fsm_e;

    typedef struct packed {
        region_e     region;
        logic [15:0] off;
    } target_t;

    function automatic logic [15:0] sec_size(strength_e s);
        return (s == STR_T24) ? 16'd1024 : 16'd512;
    endfunction

    function automatic logic [15:0] par_len(strength_e s);
        case (s)
            STR_T8:  return 16'd15;
            STR_T12: return 16'd23;
            STR_T24: return 16'd45;
            default: return 16'd0;
        endcase
    endfunction

    function automatic logic [15:0] pad_len(strength_e s);
        return (s == STR_T24) ? 16'd64 : 16'd32;
    endfunction

endpackage

// File: rtl/bch_err_select.sv
module bch_err_select
    import bch_fix_pkg::*;
(
    input  logic [AWORDS*32-1:0] addr_words,
    input  logic [DWORDS*32-1:0] data_words,
    input  logic [4:0]           idx,
    output logic [EADDR_W-1:0]   eaddr,
    output logic [7:0]           mask
);
    logic [EADDR_W-1:0] alist [MAX_ERR];
    logic [7:0]         mlist [MAX_ERR];
    logic [AWORDS-1:0]  unused_addr_bits;

    for (genvar w = 0; w < AWORDS; w++) begin : g_aw
        assign alist[2*w]     = addr_words[w*32 +: EADDR_W];
        assign alist[2*w + 1] = addr_words[w*32 + 16 +: EADDR_W];
        assign unused_addr_bits[w] = ^{addr_words[w*32 + 11 +: 5], addr_words[w*32 + 27 +: 5]};
    end

    for (genvar k = 0; k < MAX_ERR; k++) begin : g_mk
        assign mlist[k] = data_words[k*8 +: 8];
    end

    assign eaddr = (idx < 5'(MAX_ERR)) ? alist[idx] : '0;
    assign mask  = (idx < 5'(MAX_ERR)) ? mlist[idx] : '0;
endmodule

// File: rtl/bch_err_locate.sv
module bch_err_locate
    import bch_fix_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  strength_e          str,
    input  logic [EADDR_W-1:0] eaddr,
    input  logic [IDX_W-1:0]   sector_idx,
    input  logic [CNT_W-1:0]   sector_cnt,
    input  logic [8:0]         spare_len,
    output target_t            tgt
);
    logic [15:0] s, p, d, a, in_par;

    always_comb begin
        s      = sec_size(str);
        p      = par_len(str);
        d      = pad_len(str);
        a      = 16'(eaddr);
        in_par = a - (s + d - p);
        if (a < s) begin
            tgt.region = RG_DATA;
            tgt.off    = 16'(sector_idx) * s + a;
        end else if (a < s + 16'd3) begin
            tgt.region = RG_PROT;
            tgt.off    = a - s;
        end else begin
            tgt.region = RG_PAR;
            tgt.off    = 16'(spare_len) - p * 16'(sector_cnt) + p * 16'(sector_idx) + in_par;
        end
    end
endmodule

// File: rtl/bch_err_apply.sv
module bch_err_apply
    import bch_fix_pkg::*;
#(
    parameter int DADDR_W = 12,
    parameter int SADDR_W = 7,
    parameter int IDX_W   = 3,
    parameter int CNT_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [1:0]           strength,
    input  logic [IDX_W-1:0]     sector_idx,
    input  logic [CNT_W-1:0]     sector_cnt,
    input  logic [4:0]           err_cnt,
    input  logic [31:0]          spare_size,
    input  logic [AWORDS*32-1:0] err_addr_words,
    input  logic [DWORDS*32-1:0] err_data_words,
    output logic                 dmem_rd,
    output logic                 dmem_wr,
    output logic [DADDR_W-1:0]   dmem_addr,
    output logic [7:0]           dmem_wdata,
    input  logic [7:0]           dmem_rdata,
    output logic                 smem_rd,
    output logic                 smem_wr,
    output logic [SADDR_W-1:0]   smem_addr,
    output logic [31:0]          smem_wdata,
    input  logic [31:0]          smem_rdata,
    output logic                 busy,
    output logic                 done,
    output logic                 err
);
    fsm_e                 state;
    strength_e            str_q;
    logic [IDX_W-1:0]     sidx_q;
    logic [CNT_W-1:0]     scnt_q;
    logic [4:0]           cnt_q;
    logic [4:0]           idx_q;
    logic [8:0]           spare_q;
    logic [AWORDS*32-1:0] aw_q;
    logic [DWORDS*32-1:0] dw_q;
    logic                 bad_q;
    logic [22:0]          unused_spare_bits;

    logic [EADDR_W-1:0] eaddr;
    logic [7:0]         mask;
    target_t            tgt;
    logic [4:0]         cnt_clamped;
    logic               is_data;

    assign unused_spare_bits = spare_size[31:9];
    assign cnt_clamped = (err_cnt > 5'(MAX_ERR)) ? 5'(MAX_ERR) : err_cnt;

    bch_err_select u_sel (
        .addr_words (aw_q),
        .data_words (dw_q),
        .idx        (idx_q),
        .eaddr      (eaddr),
        .mask       (mask)
    );

    bch_err_locate #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_loc (
        .str        (str_q),
        .eaddr      (eaddr),
        .sector_idx (sidx_q),
        .sector_cnt (scnt_q),
        .spare_len  (spare_q),
        .tgt        (tgt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            str_q   <= STR_T8;
            sidx_q  <= '0;
            scnt_q  <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            spare_q <= '0;
            aw_q    <= '0;
            dw_q    <= '0;
            bad_q   <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    str_q   <= strength_e'(strength);
                    sidx_q  <= sector_idx;
                    scnt_q  <= sector_cnt;
                    cnt_q   <= cnt_clamped;
                    idx_q   <= '0;
                    spare_q <= spare_size[8:0];
                    aw_q    <= err_addr_words;
                    dw_q    <= err_data_words;
                    bad_q   <= (strength == 2'(STR_BAD));
                    if (strength == 2'(STR_BAD) || cnt_clamped == '0) state <= S_FIN;
                    else                                               state <= S_RD;
                end
                S_RD: state <= S_WR;
                S_WR: begin
                    if (idx_q + 5'd1 == cnt_q) state <= S_FIN;
                    else begin
                        idx_q <= idx_q + 5'd1;
                        state <= S_RD;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign is_data    = (tgt.region == RG_DATA);
    assign dmem_rd    = (state == S_RD) &&  is_data;
    assign dmem_wr    = (state == S_WR) &&  is_data;
    assign smem_rd    = (state == S_RD) && !is_data;
    assign smem_wr    = (state == S_WR) && !is_data;
    assign dmem_addr  = tgt.off[DADDR_W-1:0];
    assign smem_addr  = (tgt.region == RG_PROT) ? '0 : tgt.off[SADDR_W+1:2];
    assign dmem_wdata = dmem_rdata ^ mask;
    assign smem_wdata = smem_rdata ^ (32'(mask) << {tgt.off[1:0], 3'b000});
    assign busy       = (state != S_IDLE);
    assign done       = (state == S_FIN);
    assign err        = (state == S_FIN) && bad_q;
endmodule

// File: rtl/bch_err_apply_chk.sv
module bch_err_apply_chk #(
    parameter int DADDR_W = 12,
    parameter int SADDR_W = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               dmem_rd,
    input logic               dmem_wr,
    input logic [DADDR_W-1:0] dmem_addr,
    input logic               smem_rd,
    input logic               smem_wr,
    input logic [SADDR_W-1:0] smem_addr,
    input logic               busy,
    input logic               done,
    input logic               err
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !busy && !done && !err && !dmem_rd && !dmem_wr && !smem_rd && !smem_wr);

    assert_rmw_data_R7: assert property (@(posedge clk) disable iff (rst)
        dmem_wr |-> $past(dmem_rd) && dmem_addr == $past(dmem_addr));

    assert_rmw_spare_R7: assert property (@(posedge clk) disable iff (rst)
        smem_wr |-> $past(smem_rd) && smem_addr == $past(smem_addr));

    assert_one_memory_R7: assert property (@(posedge clk) disable iff (rst)
        !((dmem_rd || dmem_wr) && (smem_rd || smem_wr)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !dmem_rd && !dmem_wr && !smem_rd && !smem_wr && !done);

    assert_err_no_write_R10: assert property (@(posedge clk) disable iff (rst)
        err |-> done && !dmem_wr && !smem_wr);
endmodule

bind bch_err_apply bch_err_apply_chk #(.DADDR_W(DADDR_W), .SADDR_W(SADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dmem_rd   (dmem_rd),
    .dmem_wr   (dmem_wr),
    .dmem_addr (dmem_addr),
    .smem_rd   (smem_rd),
    .smem_wr   (smem_wr),
    .smem_addr (smem_addr),
    .busy      (busy),
    .done      (done),
    .err       (err)
);

// File: tb/tb_bch_err_apply.sv
module tb_bch_err_apply;
    localparam int CLK_PERIOD = 10;
    localparam int DBYTES = 4096;
    localparam int SWORDS = 128;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   strength = '0;
    logic [2:0]   sector_idx = '0;
    logic [3:0]   sector_cnt = '0;
    logic [4:0]   err_cnt = '0;
    logic [31:0]  spare_size = '0;
    logic [383:0] err_addr_words = '0;
    logic [191:0] err_data_words = '0;
    logic         dmem_rd, dmem_wr, smem_rd, smem_wr, busy, done, err;
    logic [11:0]  dmem_addr;
    logic [7:0]   dmem_wdata;
    logic [7:0]   dmem_rdata = '0;
    logic [6:0]   smem_addr;
    logic [31:0]  smem_wdata;
    logic [31:0]  smem_rdata = '0;

    logic [7:0]  dmem  [DBYTES];
    logic [31:0] smem  [SWORDS];
    logic [7:0]  exp_d [DBYTES];
    logic [31:0] exp_s [SWORDS];

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bch_err_apply dut (
        .clk(clk), .rst(rst), .start(start), .strength(strength),
        .sector_idx(sector_idx), .sector_cnt(sector_cnt), .err_cnt(err_cnt),
        .spare_size(spare_size), .err_addr_words(err_addr_words),
        .err_data_words(err_data_words),
        .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .smem_rd(smem_rd), .smem_wr(smem_wr), .smem_addr(smem_addr),
        .smem_wdata(smem_wdata), .smem_rdata(smem_rdata),
        .busy(busy), .done(done), .err(err)
    );

    always @(posedge clk) begin
        if (dmem_rd) dmem_rdata <= dmem[dmem_addr];
        if (dmem_wr) dmem[dmem_addr] <= dmem_wdata;
        if (smem_rd) smem_rdata <= smem[smem_addr];
        if (smem_wr) smem[smem_addr] <= smem_wdata;
    end

    function automatic int ssz(logic [1:0] s); return (s == 2) ? 1024 : 512; endfunction
    function automatic int pln(logic [1:0] s); return (s == 0) ? 15 : (s == 1) ? 23 : 45; endfunction
    function automatic int pad(logic [1:0] s); return (s == 2) ? 64 : 32; endfunction

    function automatic logic [383:0] put_a(logic [383:0] aw, int i, int a);
        logic [383:0] r = aw;
        r[(i/2)*32 + (i%2)*16 +: 11] = 11'(a);
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic exp_apply(logic [1:0] st, int sidx, int scnt, int cnt,
                             logic [31:0] spare, logic [383:0] aw, logic [191:0] dw);
        int n = (cnt > 24) ? 24 : cnt;
        for (int i = 0; i < n; i++) begin
            int a = int'(aw[(i/2)*32 + (i%2)*16 +: 11]);
            logic [7:0] m = dw[(i/4)*32 + (i%4)*8 +: 8];
            int s = ssz(st);
            int p = pln(st);
            if (a < s) begin
                exp_d[sidx*s + a] ^= m;
            end else if (a < s + 3) begin
                exp_s[0] ^= (32'(m) << (8*(a - s)));
            end else begin
                int off = int'(spare[8:0]) - p*scnt + p*sidx + (a - (s + pad(st) - p));
                exp_s[off/4] ^= (32'(m) << (8*(off%4)));
            end
        end
    endtask

    task automatic gen_errs(logic [1:0] st, int cnt, int region,
                            output logic [383:0] aw, output logic [191:0] dw);
        for (int w = 0; w < 12; w++) aw[w*32 +: 32] = $urandom;
        for (int w = 0; w < 6; w++)  dw[w*32 +: 32] = $urandom;
        for (int i = 0; i < cnt && i < 24; i++) begin
            int rg = (region < 0) ? int'($urandom % 3) : region;
            int s = ssz(st);
            int a;
            if (rg == 0)      a = int'($urandom % s);
            else if (rg == 1) a = s + int'($urandom % 3);
            else              a = s + pad(st) - pln(st) + int'($urandom % pln(st));
            aw = put_a(aw, i, a);
        end
    endtask

    task automatic run_case(string req, logic [1:0] st, int sidx, int scnt, int cnt,
                            logic [31:0] spare, logic [383:0] aw, logic [191:0] dw, bit poke);
        int n_eff = (st == 3) ? 0 : ((cnt > 24) ? 24 : cnt);
        int cyc = 0;
        int bad_d = 0;
        int bad_s = 0;
        bit got_err;
        if (st != 3) exp_apply(st, sidx, scnt, cnt, spare, aw, dw);
        @(negedge clk);
        strength = st; sector_idx = 3'(sidx); sector_cnt = 4'(scnt); err_cnt = 5'(cnt);
        spare_size = spare; err_addr_words = aw; err_data_words = dw; start = 1'b1;
        while (cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                start = poke;
                if (poke) begin
                    strength = 2'd0; err_cnt = 5'd24; sector_idx = '0;
                    err_addr_words = '0; err_data_words = '1;
                end
            end else if (cyc == 2) start = 1'b0;
            if (done) break;
        end
        got_err = err;
        check(done == 1'b1, req, "done reached", done, 1);
        check(cyc == 2*n_eff + 1, "R9", "cycles to done", cyc, 2*n_eff + 1);
        check(got_err == (st == 3), "R10", "err at done", got_err, (st == 3));
        @(negedge clk);
        check(!done && !busy, "R9", "done/busy after pulse", {done, busy}, 0);
        for (int k = 0; k < DBYTES; k++) if (dmem[k] !== exp_d[k]) begin
            if (bad_d == 0) $display("FAIL %s payload byte %0d: actual %0h expected %0h", req, k, dmem[k], exp_d[k]);
            bad_d++;
        end
        for (int k = 0; k < SWORDS; k++) if (smem[k] !== exp_s[k]) begin
            if (bad_s == 0) $display("FAIL %s spare word %0d: actual %0h expected %0h", req, k, smem[k], exp_s[k]);
            bad_s++;
        end
        checks += 2;
        if (bad_d != 0) errors++;
        if (bad_s != 0) errors++;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [383:0] aw;
        logic [191:0] dw;
        void'($urandom(32'd4242));
        for (int k = 0; k < DBYTES; k++) begin dmem[k] = 8'($urandom); exp_d[k] = dmem[k]; end
        for (int k = 0; k < SWORDS; k++) begin smem[k] = $urandom; exp_s[k] = smem[k]; end

        repeat (3) @(negedge clk);
        check(!busy && !done && !err && !dmem_rd && !dmem_wr && !smem_rd && !smem_wr,
              "R1", "outputs in reset", {busy, done, err}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !err, "R1", "outputs after reset", {busy, done, err}, 0);

        // R4: first and last payload byte of sector 0, T=8
        gen_errs(0, 0, 0, aw, dw);
        aw = put_a(aw, 0, 0); aw = put_a(aw, 1, 511);
        run_case("R4", 0, 0, 1, 2, 32'd64, aw, dw, 0);
        // R4: T=24 sector 3, last byte
        gen_errs(2, 0, 0, aw, dw);
        aw = put_a(aw, 0, 1023); aw = put_a(aw, 1, 0);
        run_case("R4", 2, 3, 4, 2, 32'd256, aw, dw, 0);
        // R5: all three protected lanes, T=12
        gen_errs(1, 0, 0, aw, dw);
        aw = put_a(aw, 0, 512); aw = put_a(aw, 1, 513); aw = put_a(aw, 2, 514);
        run_case("R5", 1, 1, 2, 3, 32'd128, aw, dw, 0);
        // R6: first and last parity byte, T=24, junk in upper spare bits
        gen_errs(2, 0, 0, aw, dw);
        aw = put_a(aw, 0, 1043); aw = put_a(aw, 1, 1087);
        run_case("R6", 2, 2, 4, 2, 32'hABCD_E000 | 32'd300, aw, dw, 0);
        // R7: repeated hits on one spare word
        gen_errs(0, 0, 0, aw, dw);
        aw = put_a(aw, 0, 513); aw = put_a(aw, 1, 513); aw = put_a(aw, 2, 514); aw = put_a(aw, 3, 512);
        run_case("R7", 0, 0, 4, 4, 32'd100, aw, dw, 0);
        // R8: zero errors
        gen_errs(0, 6, -1, aw, dw);
        run_case("R8", 0, 0, 4, 0, 32'd100, aw, dw, 0);
        // R8: count above 24 is clamped
        gen_errs(1, 24, 0, aw, dw);
        run_case("R8", 1, 5, 8, 30, 32'd250, aw, dw, 0);
        // R10: unsupported strength
        gen_errs(0, 5, 0, aw, dw);
        run_case("R10", 3, 0, 2, 5, 32'd64, aw, dw, 0);
        // R11: second start with scrambled inputs while busy
        gen_errs(2, 6, -1, aw, dw);
        run_case("R11", 2, 1, 2, 6, 32'd200, aw, dw, 1);

        // R2 R3: random jobs over all regions and strengths
        for (int t = 0; t < 40; t++) begin
            logic [1:0] st = 2'($urandom % 3);
            int scnt = 1 + int'($urandom % ((st == 2) ? 4 : 8));
            int sidx = int'($urandom % scnt);
            int cnt  = 1 + int'($urandom % 24);
            int smin = pln(st)*scnt + 4;
            int sp9  = smin + int'($urandom % (512 - smin));
            logic [31:0] spare = {23'($urandom), 9'(sp9)};
            gen_errs(st, cnt, -1, aw, dw);
            run_case("R2 R3", st, sidx, scnt, cnt, spare, aw, dw, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule